// File: doc/BRIEF.md
# Hub Status Change Endpoint Responder

This block answers interrupt-IN polls that reach a USB hub's status-change endpoint. It holds a small change map. The lowest bit records a change on the hub itself, and one bit above it records a change on each downstream port. Each source raises its bit with a one-cycle set pulse. The bit stays up until the request decoder sends a one-cycle clear strobe for that bit, which it does when the host issues a clear-feature request.

When the token decoder reports an IN token for this endpoint, the responder sends one of two replies to the packet transmitter. It sends a NAK handshake when nothing has changed or the device is not yet configured. Otherwise it sends a one-byte data packet that carries the change map and a DATA0/DATA1 toggle. After a data packet it waits a bounded number of cycles for the host's ACK. If no ACK arrives, it sends the same byte with the same toggle at the next poll.

Token decoding, CRC, bit stuffing and the control endpoint belong to neighbouring blocks.

Top module: `stchg_ep_responder`

## Requirements
- R1: In the data byte, bit 0 is the hub's own change and bit k (1 to NUM_PORTS) is port k's change. Bits above NUM_PORTS are always 0.
- R2: When configured, idle, with no pending resend and an all-zero change map, a token produces a one-cycle `tx_nak_o` in the cycle after the token and no data.
- R3: When configured, idle, with no pending resend and a non-zero map, a token produces a one-cycle `tx_data_o` in the cycle after the token. The byte is the map as it stood before that cycle's set and clear inputs took effect.
- R4: A change bit stays set across any number of polls until its clear strobe. A set and a clear on the same bit in the same cycle leave it set.
- R5: While `configured_i` is low, every token gets a NAK, the data toggle is held at DATA0 (`tx_pid_o`=0), and any pending resend is dropped. The change map keeps collecting.
- R6: An `ack_i` in any of the ACK_TIMEOUT cycles after a data reply inverts the toggle used by the next fresh data packet.
- R7: If no ACK arrives in that window, the next token resends the held byte with the unchanged toggle, even if the map has changed since.
- R8: A token that arrives while an ACK is awaited gets no reply. An `ack_i` outside the window has no effect.
- R9: After reset the outputs are low, the map is empty and the toggle is DATA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| configured_i | input | 1 | Device configured by the host |
| set_hub_i | input | 1 | Pulse: hub-level change detected |
| set_port_i | input | NUM_PORTS | Pulse per port: port change detected |
| clr_hub_i | input | 1 | Strobe: host cleared the hub change |
| clr_port_i | input | NUM_PORTS | Strobe per port: host cleared that port change |
| tok_in_i | input | 1 | Pulse: IN token for this endpoint accepted |
| ack_i | input | 1 | Pulse: host ACK handshake received |
| tx_nak_o | output | 1 | Pulse: send a NAK handshake |
| tx_data_o | output | 1 | Pulse: send a data packet with `tx_byte_o` |
| tx_pid_o | output | 1 | Toggle for the data packet: 0 = DATA0, 1 = DATA1 |
| tx_byte_o | output | 8 | Change byte to transmit |

## Verification
The bench builds the block with four ports and a shortened ACK window of six cycles. This makes window expiry, an ACK in the last window cycle, and a token that lands inside the window cheap to reach. A behavioural model predicts every reply, byte and toggle on every clock, over these cases:
- polls before configuration
- set and clear collisions on the same bit
- a token that coincides with a set pulse
- a resend after the map has changed
- dropping configuration during a pending resend

// File: rtl/stchg_pkg.sv
// Shared types for the status-change endpoint responder.
package stchg_pkg;
    // Responder phase: idle, or waiting for the host ACK after data.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } resp_state_t;
endpackage

// File: rtl/stchg_bitmap.sv
// Change map: one sticky bit per source (bit 0 hub, bits 1.. ports).
// Assumes set and clear inputs are single-cycle pulses from the clock
// domain of clk. A set in the same cycle as a clear wins.
module stchg_bitmap #(
    parameter int MAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAP_W-1:0] set_i,
    input  logic [MAP_W-1:0] clr_i,
    output logic [MAP_W-1:0] bits_o
);
    logic [MAP_W-1:0] bits_q;

    for (genvar k = 0; k < MAP_W; k++) begin : g_bit
        // Sticky bit: set wins over clear, otherwise hold until cleared.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits_q[k] <= 1'b0;
            else if (set_i[k])
                bits_q[k] <= 1'b1;
            else if (clr_i[k])
                bits_q[k] <= 1'b0;
        end
    end

    assign bits_o = bits_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(set_i) & ~bits_q) == '0)); // R4

    AST_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(bits_q) & ~bits_q & ~$past(clr_i)) == '0)); // R4
endmodule

// File: rtl/stchg_resp.sv
// Reply engine: turns an accepted IN token into either a NAK or a data
// packet. It tracks the DATA0/DATA1 toggle and the ACK wait window.
// Assumes tok_i and ack_i are single-cycle pulses and that the
// transmitter takes the reply in the cycle it is presented.
module stchg_resp
    import stchg_pkg::*;
#(
    parameter int MAP_W       = 5,
    parameter int ACK_TIMEOUT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_i,
    input  logic             tok_i,
    input  logic             ack_i,
    input  logic [MAP_W-1:0] bits_i,
    output logic             nak_o,
    output logic             data_o,
    output logic             pid_o,
    output logic [7:0]       byte_o
);
    localparam int CNT_W = (ACK_TIMEOUT > 2) ? $clog2(ACK_TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_TIMEOUT - 1);

    resp_state_t      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pid_q;
    logic             retry_q;
    logic [MAP_W-1:0] held_q;
    logic             nak_q;
    logic             data_q;
    logic             pid_out_q;

    // Reply sequencing: token handling, ACK window, toggle and resend flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            pid_q     <= 1'b0;
            retry_q   <= 1'b0;
            held_q    <= '0;
            nak_q     <= 1'b0;
            data_q    <= 1'b0;
            pid_out_q <= 1'b0;
        end else begin
            nak_q  <= 1'b0;
            data_q <= 1'b0;
            if (!cfg_i) begin
                state_q <= ST_IDLE;
                pid_q   <= 1'b0;
                retry_q <= 1'b0;
                nak_q   <= tok_i;
            end else if (state_q == ST_IDLE) begin
                if (tok_i) begin
                    if (retry_q || (bits_i != '0)) begin
                        if (!retry_q)
                            held_q <= bits_i;
                        data_q    <= 1'b1;
                        pid_out_q <= pid_q;
                        state_q   <= ST_WAIT;
                        cnt_q     <= '0;
                    end else begin
                        nak_q <= 1'b1;
                    end
                end
            end else begin
                if (ack_i) begin
                    pid_q   <= ~pid_q;
                    retry_q <= 1'b0;
                    state_q <= ST_IDLE;
                end else if (cnt_q == CNT_LAST) begin
                    retry_q <= 1'b1;
                    state_q <= ST_IDLE;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Zero-extend the held map into the transmitted byte.
    always_comb begin
        byte_o = '0;
        byte_o[MAP_W-1:0] = held_q;
    end

    assign nak_o  = nak_q;
    assign data_o = data_q;
    assign pid_o  = pid_out_q;

    AST_SINGLE_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(nak_o && data_o)); // R2

    AST_REPLY_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (nak_o || data_o) |-> $past(tok_i)); // R8

    AST_DATA_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        data_o |-> $past(cfg_i)); // R5

    AST_DATA_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        data_o |-> (byte_o != 8'h00)); // R3

    AST_TOGGLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (pid_q != $past(pid_q))) |-> ($past(ack_i) || !$past(cfg_i))); // R6
endmodule

// File: rtl/stchg_ep_responder.sv
// Top of the hub status-change endpoint responder. It gathers the hub
// and per-port change sources into one map and answers polls from it.
// Assumes NUM_PORTS is at most 7, so the map fits in one byte.
module stchg_ep_responder #(
    parameter int NUM_PORTS   = 4,
    parameter int ACK_TIMEOUT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 configured_i,
    input  logic                 set_hub_i,
    input  logic [NUM_PORTS-1:0] set_port_i,
    input  logic                 clr_hub_i,
    input  logic [NUM_PORTS-1:0] clr_port_i,
    input  logic                 tok_in_i,
    input  logic                 ack_i,
    output logic                 tx_nak_o,
    output logic                 tx_data_o,
    output logic                 tx_pid_o,
    output logic [7:0]           tx_byte_o
);
    localparam int MAP_W = NUM_PORTS + 1;

    logic [MAP_W-1:0] map_w;

    stchg_bitmap #(.MAP_W(MAP_W)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ({set_port_i, set_hub_i}),
        .clr_i  ({clr_port_i, clr_hub_i}),
        .bits_o (map_w)
    );

    stchg_resp #(.MAP_W(MAP_W), .ACK_TIMEOUT(ACK_TIMEOUT)) u_resp (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_i  (configured_i),
        .tok_i  (tok_in_i),
        .ack_i  (ack_i),
        .bits_i (map_w),
        .nak_o  (tx_nak_o),
        .data_o (tx_data_o),
        .pid_o  (tx_pid_o),
        .byte_o (tx_byte_o)
    );
endmodule

// File: tb/stchg_ep_responder_tb.sv
// Bench: behavioural reference model compared on every clock, plus
// directed polls with hand-computed replies.
module stchg_ep_responder_tb;
    localparam int NP = 4;
    localparam int TO = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic configured_i = 1'b0;
    logic set_hub_i = 1'b0, clr_hub_i = 1'b0;
    logic [NP-1:0] set_port_i = '0, clr_port_i = '0;
    logic tok_in_i = 1'b0, ack_i = 1'b0;
    logic tx_nak_o, tx_data_o, tx_pid_o;
    logic [7:0] tx_byte_o;

    int checks = 0;
    int errors = 0;

    stchg_ep_responder #(.NUM_PORTS(NP), .ACK_TIMEOUT(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .configured_i(configured_i),
        .set_hub_i(set_hub_i), .set_port_i(set_port_i),
        .clr_hub_i(clr_hub_i), .clr_port_i(clr_port_i),
        .tok_in_i(tok_in_i), .ack_i(ack_i),
        .tx_nak_o(tx_nak_o), .tx_data_o(tx_data_o),
        .tx_pid_o(tx_pid_o), .tx_byte_o(tx_byte_o)
    );

    always #5 clk = ~clk;

    // Reference model state.
    int  m_bits = 0, m_held = 0, m_cnt = 0;
    bit  m_wait = 0, m_pid = 0, m_retry = 0;
    bit  e_nak = 0, e_data = 0, e_pid = 0;
    int  e_byte = 0;

    always @(posedge clk) begin
        int setv, clrv;
        setv = {set_port_i, set_hub_i};
        clrv = {clr_port_i, clr_hub_i};
        if (!rst_n) begin
            m_bits = 0; m_held = 0; m_cnt = 0; m_wait = 0; m_pid = 0;
            m_retry = 0; e_nak = 0; e_data = 0; e_pid = 0; e_byte = 0;
        end else begin
            e_nak = 0; e_data = 0;
            if (!configured_i) begin
                m_wait = 0; m_pid = 0; m_retry = 0;
                if (tok_in_i) e_nak = 1;
            end else if (!m_wait) begin
                if (tok_in_i) begin
                    if (m_retry || m_bits != 0) begin
                        if (!m_retry) m_held = m_bits;
                        e_data = 1; e_pid = m_pid; e_byte = m_held;
                        m_wait = 1; m_cnt = 0;
                    end else e_nak = 1;
                end
            end else begin
                if (ack_i) begin m_pid = !m_pid; m_retry = 0; m_wait = 0; end
                else if (m_cnt == TO - 1) begin m_retry = 1; m_wait = 0; end
                else m_cnt++;
            end
            m_bits = (m_bits & ~clrv) | setv;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2/R5 nak reply", tx_nak_o, e_nak);
            chk("R3/R8 data reply", tx_data_o, e_data);
            if (e_data) begin
                chk("R1/R3 data byte", tx_byte_o, e_byte);
                chk("R6/R7 data toggle", tx_pid_o, e_pid);
            end
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One poll; afterwards the reply is visible on the outputs.
    task automatic poll(string tag, bit exp_data, int exp_byte, bit exp_pid);
        @(negedge clk);
        tok_in_i = 1'b1;
        @(negedge clk);
        tok_in_i = 1'b0;
        chk(tag, tx_data_o, exp_data);
        chk(tag, tx_nak_o, !exp_data);
        if (exp_data) begin
            chk(tag, tx_byte_o, exp_byte);
            chk(tag, tx_pid_o, exp_pid);
        end
    endtask

    task automatic pulse_ack;
        @(negedge clk); ack_i = 1'b1;
        @(negedge clk); ack_i = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        // R9: reset state.
        chk("R9 reset nak", tx_nak_o, 0);
        chk("R9 reset data", tx_data_o, 0);
        chk("R9 reset toggle", tx_pid_o, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        poll("R5 unconfigured empty", 0, 0, 0);
        @(negedge clk); set_hub_i = 1; set_port_i = 4'b0010;
        @(negedge clk); set_hub_i = 0; set_port_i = '0;
        poll("R5 unconfigured with changes", 0, 0, 0);
        @(negedge clk); configured_i = 1'b1;
        poll("R1 hub+port2 byte", 1, 8'h05, 0);
        pulse_ack();
        idle(TO);
        poll("R4 still reported", 1, 8'h05, 1);
        pulse_ack();
        idle(TO);
        // R4: clear hub and set port4 in the same cycle; set and clear port2 together.
        @(negedge clk); clr_hub_i = 1; set_port_i = 4'b1010; clr_port_i = 4'b0010;
        @(negedge clk); clr_hub_i = 0; set_port_i = '0; clr_port_i = '0;
        poll("R4 set wins over clear", 1, 8'h14, 0);
        // R8: token inside the ACK window gets no reply.
        idle(1);
        @(negedge clk); tok_in_i = 1;
        @(negedge clk); tok_in_i = 0;
        chk("R8 token in window", tx_nak_o | tx_data_o, 0);
        @(negedge clk); clr_port_i = 4'b0010;
        @(negedge clk); clr_port_i = '0;
        idle(TO);
        poll("R7 resend held byte", 1, 8'h14, 0);
        idle(TO - 2);
        pulse_ack();  // ACK in last window cycle
        idle(2);
        pulse_ack();  // outside window, ignored
        poll("R6 toggle after ack", 1, 8'h10, 1);
        pulse_ack();
        idle(TO);
        @(negedge clk); clr_port_i = 4'b1000;
        @(negedge clk); clr_port_i = '0;
        poll("R2 empty map nak", 0, 0, 0);
        // R3: set pulse in the token cycle is not in this reply.
        @(negedge clk); tok_in_i = 1; set_port_i = 4'b0001;
        @(negedge clk); tok_in_i = 0; set_port_i = '0;
        chk("R3 capture before set", tx_nak_o, 1);
        poll("R3 next poll sees set", 1, 8'h02, 0);
        idle(TO + 1);
        // R5: drop configuration while a resend is pending.
        @(negedge clk); configured_i = 0;
        @(negedge clk); configured_i = 1;
        @(negedge clk); set_hub_i = 1;
        @(negedge clk); set_hub_i = 0;
        poll("R5 reconfig fresh capture", 1, 8'h03, 0);
        pulse_ack();
        idle(TO + 2);
        summary();
        $finish;
    end
endmodule